// File: doc/BRIEF.md
# Serial Frame Parity and Break Logic

This block frames characters for one asynchronous serial channel. On the transmit side a byte is accepted over a valid/ready handshake and sent on `txd`. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The receive side watches `rxd`, confirms a start bit at mid-bit, samples every later bit at its own centre, and rebuilds the character. It flags a parity mismatch and a missing stop bit. All bit timing comes from a single-cycle `baud_tick` strobe that runs at sixteen times the bit rate.

Parity is chosen by three controls: enable, even select and force. With force set, the parity bit is a fixed mark (1) or space (0), and this applies to both directions. A break control pulls `txd` low for as long as it is held. The frame being sent keeps running underneath the break and finishes on its own schedule.

The transmitter has the states TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP. It moves TX_IDLE→TX_START when a byte is accepted. It moves TX_START→TX_DATA after 16 ticks. It moves TX_DATA→TX_PAR, or TX_DATA→TX_STOP when parity is off, after the last data bit. It moves TX_PAR→TX_STOP after one bit time, and TX_STOP→TX_IDLE after one or two stop bit times. The receiver has the states RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP. It moves RX_IDLE→RX_START when it sees a low line on a tick. It moves RX_START→RX_DATA when the line is still low at mid-bit, and RX_START→RX_IDLE when the line is high there. It moves RX_DATA→RX_PAR, or RX_DATA→RX_STOP when parity is off, after the last data bit. It moves RX_PAR→RX_STOP after one bit, and RX_STOP→RX_IDLE when the stop bit is sampled, which is also when the result is reported.

Top module: `uart_frame_core`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A transmitted frame is one start bit at 0, then N data bits least significant bit first, then the parity bit when enabled, then stop bits at 1. N is 5, 6, 7 or 8 for `cfg_word_len` codes 00, 01, 10 and 11. Each bit lasts 16 ticks.
- R3: With `cfg_parity_en` at 0, no parity bit is sent and none is checked, whatever the even and force controls are set to. The stop bit directly follows the data bits.
- R4: Enable 1, force 0, even 0 selects odd parity: data ones plus the parity bit give an odd count. This is the reset default.
- R5: Enable 1, force 0, even 1 selects even parity: data ones plus the parity bit give an even count.
- R6: Enable 1, force 1, even 0 fixes the parity bit at 1 on transmit. On receive, any other value is a parity error.
- R7: Enable 1, force 1, even 1 fixes the parity bit at 0 on transmit. On receive, any other value is a parity error.
- R8: `cfg_two_stop` at 1 sends two stop bits and at 0 sends one. `tx_ready` stays 0 until the last stop bit ends.
- R9: While `cfg_break` is 1, `txd` is 0 from the next clock onward. It returns to normal only when `cfg_break` is cleared. The frame in progress keeps counting and completes underneath the break.
- R10: The receiver confirms a start bit 8 ticks after it sees the line low. A low pulse shorter than that produces no character.
- R11: The receiver pulses `rx_valid` for one cycle with the rebuilt character in `rx_data`. Bits above the word length are 0. `rx_parity_err` is set when the received parity bit differs from the one the current controls call for.
- R12: `rx_frame_err` is set when the first stop bit is sampled as 0.
- R13: A byte is taken when `tx_valid` and `tx_ready` are both 1 on a clock edge. The word length, stop count and parity value are captured at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| cfg_word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_parity_en | input | 1 | 1 = parity bit present |
| cfg_parity_even | input | 1 | Even select, or space when forced |
| cfg_parity_force | input | 1 | 1 = fixed (stick) parity |
| cfg_break | input | 1 | 1 = hold txd low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter idle, can take a byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | One-cycle pulse, new character |
| rx_parity_err | output | 1 | Parity mismatch on last character |
| rx_frame_err | output | 1 | Stop bit low on last character |

## Verification
The bench aims at the parity code corners. With parity disabled but force and space selected, a design that still emits a parity bit puts a 0 where the stop bit belongs. Mark and space parity are checked on receive with the wrong bit value, so a receiver that computes ordinary parity while force is set misses the error. A start glitch shorter than half a bit checks that a design without mid-bit confirmation does not report a character. Break is raised over a frame of all ones, so a design that gates the data instead of the line, or stalls the shift state, shows either a high `txd` or a late `tx_ready`.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
    } rx_result_t;

    // Number of data bits for a word length code (5..8).
    function automatic logic [3:0] data_bits(input logic [1:0] wlen);
        return 4'd5 + {2'b00, wlen};
    endfunction

    // Mask of the data bits in use for a word length code.
    function automatic logic [7:0] word_mask(input logic [1:0] wlen);
        return 8'hFF >> (2'd3 - wlen);
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/frame_parity.sv
module frame_parity
    import uart_frame_pkg::*;
(
    input  logic [7:0] data,
    input  logic [1:0] wlen,
    input  logic       even_sel,
    input  logic       force_sel,
    output logic       pbit
);
    logic [7:0] used;

    assign used = data & word_mask(wlen);

    always_comb begin
        if (force_sel)     pbit = ~even_sel;   // stick: mark or space
        else if (even_sel) pbit = ^used;       // even total
        else               pbit = ~^used;      // odd total
    end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
    import uart_frame_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] wlen,
    input  logic       stop2,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_force,
    input  logic       brk,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);

    tx_state_e  state, state_n;
    logic [CW-1:0] cnt;
    logic [2:0] bit_idx;
    logic       stop_idx;
    logic [7:0] shreg;
    logic       par_q;
    logic [1:0] wlen_q;
    logic       stop2_q;
    logic       paren_q;
    logic       pbit_now;
    logic       line;
    logic       accept;
    logic       bit_end;
    logic       last_data;
    logic [3:0] nbits;

    frame_parity u_par (
        .data      (tx_data),
        .wlen      (wlen),
        .even_sel  (par_even),
        .force_sel (par_force),
        .pbit      (pbit_now)
    );

    assign accept    = (state == TX_IDLE) && tx_valid;
    assign bit_end   = tick && (cnt == LAST_TICK);
    assign nbits     = data_bits(wlen_q);
    assign last_data = ({1'b0, bit_idx} == (nbits - 4'd1));
    assign tx_ready  = (state == TX_IDLE);

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            TX_IDLE:  if (tx_valid) state_n = TX_START;
            TX_START: if (bit_end) state_n = TX_DATA;
            TX_DATA:  if (bit_end && last_data) state_n = paren_q ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) state_n = TX_STOP;
            TX_STOP:  if (bit_end && (stop_idx == stop2_q)) state_n = TX_IDLE;
            default:  state_n = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_n;
    end

    // Bit timing and captured frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            shreg    <= '0;
            par_q    <= 1'b0;
            wlen_q   <= 2'b11;
            stop2_q  <= 1'b0;
            paren_q  <= 1'b0;
        end else begin
            if (state != state_n)        cnt <= '0;
            else if (tick)               cnt <= (cnt == LAST_TICK) ? '0 : cnt + 1'b1;

            if (state != TX_DATA)        bit_idx <= '0;
            else if (bit_end)            bit_idx <= bit_idx + 3'd1;

            if (state != TX_STOP)        stop_idx <= 1'b0;
            else if (bit_end)            stop_idx <= 1'b1;

            if (accept) begin
                shreg   <= tx_data;
                par_q   <= pbit_now;
                wlen_q  <= wlen;
                stop2_q <= stop2;
                paren_q <= par_en;
            end
        end
    end

    // Line level per state
    always_comb begin
        unique case (state)
            TX_IDLE:  line = 1'b1;
            TX_START: line = 1'b0;
            TX_DATA:  line = shreg[bit_idx];
            TX_PAR:   line = par_q;
            TX_STOP:  line = 1'b1;
            default:  line = 1'b1;
        endcase
    end

    // Registered output with break override
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txd <= 1'b1;
        else        txd <= brk ? 1'b0 : line;
    end

    AST_TX_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !txd); // R9
    AST_TX_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready); // R13
    AST_TX_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_DATA) |-> ({1'b0, bit_idx} < nbits)); // R2
    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START && !brk && $past(state == TX_START)) |=> !txd); // R2
endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import uart_frame_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxs,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_force,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_par_err,
    output logic       rx_frm_err
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);
    localparam logic [CW-1:0] MID_TICK  = CW'(OSR / 2 - 1);

    rx_state_e  state, state_n;
    logic [CW-1:0] cnt;
    logic [2:0] bit_idx;
    logic [7:0] sreg;
    logic       par_bit;
    logic       exp_pbit;
    logic       bit_end;
    logic       last_data;
    rx_result_t res;
    logic       valid_q;

    frame_parity u_chk (
        .data      (sreg),
        .wlen      (wlen),
        .even_sel  (par_even),
        .force_sel (par_force),
        .pbit      (exp_pbit)
    );

    assign bit_end   = tick && (cnt == LAST_TICK);
    assign last_data = ({1'b0, bit_idx} == (data_bits(wlen) - 4'd1));

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE:  if (tick && !rxs) state_n = RX_START;
            RX_START: if (tick && (cnt == MID_TICK)) state_n = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && last_data) state_n = par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (bit_end) state_n = RX_STOP;
            RX_STOP:  if (bit_end) state_n = RX_IDLE;
            default:  state_n = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    // Sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            sreg    <= '0;
            par_bit <= 1'b0;
        end else begin
            if (state != state_n)   cnt <= '0;
            else if (tick)          cnt <= (cnt == LAST_TICK) ? '0 : cnt + 1'b1;

            if (state != RX_DATA)   bit_idx <= '0;
            else if (bit_end)       bit_idx <= bit_idx + 3'd1;

            if (state == RX_START)                 sreg <= '0;
            else if (state == RX_DATA && bit_end)  sreg[bit_idx] <= rxs;

            if (state == RX_PAR && bit_end) par_bit <= rxs;
        end
    end

    // Outputs: result register and valid pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res     <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (state == RX_STOP && bit_end) begin
                valid_q     <= 1'b1;
                res.data    <= sreg;
                res.par_err <= par_en && (par_bit != exp_pbit);
                res.frm_err <= !rxs;
            end
        end
    end

    assign rx_data    = res.data;
    assign rx_par_err = res.par_err;
    assign rx_frm_err = res.frm_err;
    assign rx_valid   = valid_q;

    AST_RX_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R11
    AST_RX_NO_PAR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(par_en)) |-> !rx_par_err); // R3
    AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data & ~word_mask($past(wlen))) == 8'h00)); // R11
    AST_RX_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && tick && cnt == MID_TICK && rxs) |=> (state == RX_IDLE)); // R10
endmodule

// File: rtl/uart_frame_core.sv
module uart_frame_core #(
    parameter int OSR        = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic [1:0] cfg_word_len,
    input  logic       cfg_two_stop,
    input  logic       cfg_parity_en,
    input  logic       cfg_parity_even,
    input  logic       cfg_parity_force,
    input  logic       cfg_break,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_parity_err,
    output logic       rx_frame_err
);
    logic rx_sampled;

    rx_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_sampled)
    );

    frame_tx #(.OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .wlen      (cfg_word_len),
        .stop2     (cfg_two_stop),
        .par_en    (cfg_parity_en),
        .par_even  (cfg_parity_even),
        .par_force (cfg_parity_force),
        .brk       (cfg_break),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .txd       (txd)
    );

    frame_rx #(.OSR(OSR)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .rxs        (rx_sampled),
        .wlen       (cfg_word_len),
        .par_en     (cfg_parity_en),
        .par_even   (cfg_parity_even),
        .par_force  (cfg_parity_force),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_par_err (rx_parity_err),
        .rx_frm_err (rx_frame_err)
    );

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !cfg_break && $past(tx_ready) && !$past(cfg_break)) |-> txd); // R1
endmodule

// File: tb/sim_uart_frame_core.sv
module sim_uart_frame_core;
    localparam int TDIV = 3;
    localparam int BITC = 16 * TDIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick;
    logic [1:0] cfg_word_len = 2'b11;
    logic cfg_two_stop = 1'b0, cfg_parity_en = 1'b1, cfg_parity_even = 1'b0;
    logic cfg_parity_force = 1'b0, cfg_break = 1'b0;
    logic [7:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready, txd, rxd;
    logic [7:0] rx_data;
    logic rx_valid, rx_parity_err, rx_frame_err;
    logic use_loop = 1'b1;
    logic rxd_drv = 1'b1;
    int   tc;
    int   checks = 0;
    int   failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign rxd = use_loop ? txd : rxd_drv;

    always @(posedge clk) begin
        if (!rst_n) begin
            tc <= 0; baud_tick <= 1'b0;
        end else begin
            tc <= (tc == TDIV - 1) ? 0 : tc + 1;
            baud_tick <= (tc == TDIV - 1);
        end
    end

    uart_frame_core u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .cfg_word_len(cfg_word_len), .cfg_two_stop(cfg_two_stop),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_even(cfg_parity_even),
        .cfg_parity_force(cfg_parity_force), .cfg_break(cfg_break),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] wl);
        return 8'hFF >> (3 - wl);
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] wl,
                                     input logic ev, input logic fo);
        int ones;
        if (fo) return ~ev;
        ones = $countones(d & mask_of(wl));
        return ev ? logic'(ones % 2) : logic'(!(ones % 2));
    endfunction

    function automatic string par_tag(input logic en, input logic ev, input logic fo);
        if (!en) return "R3";
        if (!fo) return ev ? "R5" : "R4";
        return ev ? "R7" : "R6";
    endfunction

    task automatic set_cfg(input logic [1:0] wl, input logic s2, input logic en,
                           input logic ev, input logic fo);
        @(negedge clk);
        cfg_word_len = wl; cfg_two_stop = s2; cfg_parity_en = en;
        cfg_parity_even = ev; cfg_parity_force = fo;
    endtask

    task automatic wait_rx(output bit got, output logic [7:0] d, output logic pe, output logic fe);
        got = 0; d = '0; pe = 0; fe = 0;
        for (int i = 0; i < 20 * BITC && !got; i++) begin
            @(posedge clk); #1;
            if (rx_valid) begin
                got = 1; d = rx_data; pe = rx_parity_err; fe = rx_frame_err;
            end
        end
    endtask

    task automatic loop_frame(input logic [7:0] d);
        int nb;
        logic [7:0] cap, m, rd;
        logic sb, pb, s1, s2, r1, r2, rdy_end, pe, fe;
        bit got;
        string pt;
        nb = 5 + int'(cfg_word_len);
        m = mask_of(cfg_word_len);
        cap = '0; pb = 1'b1; s2 = 1'b0; r2 = 1'b1;
        pt = par_tag(cfg_parity_en, cfg_parity_even, cfg_parity_force);
        use_loop = 1'b1;
        fork
            begin
                @(negedge clk); tx_data = d; tx_valid = 1'b1;
                @(negedge clk); tx_valid = 1'b0;
            end
            begin
                int guard = 0;
                do begin @(negedge clk); guard++; end while (txd !== 1'b0 && guard < 2000);
                repeat (BITC / 2) @(negedge clk); sb = txd;
                for (int i = 0; i < nb; i++) begin repeat (BITC) @(negedge clk); cap[i] = txd; end
                if (cfg_parity_en) begin repeat (BITC) @(negedge clk); pb = txd; end
                repeat (BITC) @(negedge clk); s1 = txd; r1 = tx_ready;
                if (cfg_two_stop) begin repeat (BITC) @(negedge clk); s2 = txd; r2 = tx_ready; end
                repeat (BITC) @(negedge clk); rdy_end = tx_ready;
            end
            begin
                wait_rx(got, rd, pe, fe);
            end
        join
        chk("R2 start bit", sb, 0);
        chk("R2 data bits lsb first", cap, d & m);
        if (cfg_parity_en)
            chk({pt, " tx parity bit"}, pb, exp_par(d, cfg_word_len, cfg_parity_even, cfg_parity_force));
        chk({pt, " bit after data is stop"}, s1, 1);
        if (cfg_two_stop) chk("R8 second stop high and busy", {s2, r2}, 2'b10);
        else              chk("R8 busy during stop", r1, 0);
        chk("R8 R13 ready after frame", rdy_end, 1);
        chk("R11 rx valid seen", got, 1);
        chk("R11 rx data", rd, d & m);
        chk({pt, " no rx parity error"}, pe, 0);
        chk("R12 no framing error", fe, 0);
    endtask

    task automatic raw_frame(input logic [7:0] d, input logic has_par, input logic pbit,
                             input logic stopb, output bit got, output logic [7:0] rd,
                             output logic pe, output logic fe);
        int nb;
        nb = 5 + int'(cfg_word_len);
        use_loop = 1'b0;
        fork
            begin
                @(negedge clk); rxd_drv = 1'b0;
                repeat (BITC) @(negedge clk);
                for (int i = 0; i < nb; i++) begin rxd_drv = d[i]; repeat (BITC) @(negedge clk); end
                if (has_par) begin rxd_drv = pbit; repeat (BITC) @(negedge clk); end
                rxd_drv = stopb; repeat (BITC) @(negedge clk);
                rxd_drv = 1'b1; repeat (2 * BITC) @(negedge clk);
            end
            begin
                wait_rx(got, rd, pe, fe);
            end
        join
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit got;
        logic [7:0] rd;
        logic pe, fe;
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20260117);

        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd idle", txd, 1);
        chk("R1 tx_ready", tx_ready, 1);
        chk("R1 rx_valid", rx_valid, 0);

        // Directed transmit/loopback corners
        loop_frame(8'hA5);                       // default: 8 bits, odd (R4)
        set_cfg(2'b11, 0, 1, 1, 0); loop_frame(8'hA5);   // R5 even
        set_cfg(2'b11, 0, 1, 0, 1); loop_frame(8'h00);   // R6 mark
        set_cfg(2'b11, 0, 1, 1, 1); loop_frame(8'hFF);   // R7 space
        set_cfg(2'b11, 0, 0, 1, 1); loop_frame(8'h3C);   // R3 disabled over space
        set_cfg(2'b00, 1, 1, 0, 0); loop_frame(8'hF3);   // 5 bits, two stops
        set_cfg(2'b01, 0, 1, 1, 0); loop_frame(8'h6A);
        set_cfg(2'b10, 1, 0, 0, 0); loop_frame(8'hD5);

        // Random loopback frames
        for (int n = 0; n < 40; n++) begin
            set_cfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                    1'($urandom % 2), 1'($urandom % 2));
            loop_frame(8'($urandom));
        end

        // Receive parity error detection
        set_cfg(2'b11, 0, 1, 1, 0);
        raw_frame(8'h01, 1, 1'b0, 1'b1, got, rd, pe, fe);
        chk("R5 rx wrong even parity flagged", {got, pe, fe}, 3'b110);
        chk("R11 rx data with error", rd, 8'h01);
        set_cfg(2'b11, 0, 1, 0, 1);
        raw_frame(8'h03, 1, 1'b0, 1'b1, got, rd, pe, fe);
        chk("R6 rx space where mark expected", {got, pe}, 2'b11);
        raw_frame(8'h03, 1, 1'b1, 1'b1, got, rd, pe, fe);
        chk("R6 rx mark accepted regardless of data", {got, pe}, 2'b10);
        set_cfg(2'b11, 0, 1, 1, 1);
        raw_frame(8'h80, 1, 1'b1, 1'b1, got, rd, pe, fe);
        chk("R7 rx mark where space expected", {got, pe}, 2'b11);
        set_cfg(2'b11, 0, 0, 1, 1);
        raw_frame(8'h5A, 0, 1'b0, 1'b1, got, rd, pe, fe);
        chk("R3 rx no parity slot", {got, pe, fe}, 3'b100);
        chk("R3 rx data", rd, 8'h5A);

        // Framing error
        set_cfg(2'b10, 0, 0, 0, 0);
        raw_frame(8'h7F, 0, 1'b0, 1'b0, got, rd, pe, fe);
        chk("R12 stop low flagged", {got, fe}, 2'b11);
        chk("R11 short word upper bits zero", rd, 8'h7F);

        // Start glitch shorter than half a bit
        use_loop = 1'b0;
        @(negedge clk); rxd_drv = 1'b0;
        repeat (3 * TDIV) @(negedge clk); rxd_drv = 1'b1;
        got = 0;
        for (int i = 0; i < 3 * BITC; i++) begin
            @(posedge clk); #1;
            if (rx_valid) got = 1;
        end
        chk("R10 glitch rejected", got, 0);
        set_cfg(2'b11, 0, 1, 0, 0);
        raw_frame(8'hC3, 1, exp_par(8'hC3, 2'b11, 0, 0), 1'b1, got, rd, pe, fe);
        chk("R10 frame after glitch", {got, rd, pe, fe}, {1'b1, 8'hC3, 2'b00});

        // Break over a frame of ones
        set_cfg(2'b11, 0, 0, 0, 0);
        use_loop = 1'b0;
        @(negedge clk); tx_data = 8'hFF; tx_valid = 1'b1;
        @(negedge clk); tx_valid = 1'b0;
        repeat (3 * BITC) @(negedge clk);
        cfg_break = 1'b1;
        @(negedge clk);
        chk("R9 txd low next clock", txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            chk("R9 txd held low", txd, 0);
        end
        chk("R9 frame completed under break", tx_ready, 1);
        cfg_break = 1'b0;
        @(negedge clk);
        chk("R9 txd released", txd, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule